// File: doc/BRIEF.md
# Bit-Serial Masked-Tap CRC Engine

This block computes a cyclic redundancy check one bit at a time. It uses an external shift register: at every step the state is ANDed with a programmable polynomial mask and reduced to one parity bit. A single start pulse, given while the engine is idle, loads the configuration: the polynomial mask, the starting state, the CRC length n (1 to 32) and a message word of k bits (0 to 32). The engine then runs two phases on its own.

In the first phase the engine absorbs the message bits, most significant first. Each parity bit is XORed with the current message bit and shifted into the state from the bottom. In the second phase there is no feedback. The engine reads out n parity bits, one per step, and shifts each into a result register. Every bit takes two clock cycles: one cycle registers the parity and the next cycle performs the shift. When the result is complete, a one-cycle done pulse marks it, and a valid flag stays high until the next accepted start.

Top module: `lfsr_crc_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `valid` are 0 and `crc_out` is 0.
- R2: A `start` pulse seen while `busy` is 0 loads the configuration, clears `valid`, and makes `busy` read 1 from the next cycle on.
- R3: Absorb step: the feedback is the XOR of the parity of (state AND mask) with the message bit. The state shifts left by one and the feedback enters bit 0. Mask bit j taps state bit j, so mask bit 0 carries the polynomial's highest-order coefficient.
- R4: The message bits are bits k-1 down to 0 of `msg_word`, where k = `msg_len`, and they are taken in that order. Bits of `msg_word` at position k and above are ignored.
- R5: Extract step: each output bit is the parity of (state AND mask), taken before that step's shift. The state then shifts left with 0 entering bit 0. This repeats n times.
- R6: Each output bit enters bit 0 of `crc_out` while `crc_out` shifts left. The first output bit ends at bit n-1, and bits n and above are 0.
- R7: The state is n bits wide. State bits at position n and above, including those of `cfg_init`, are held at 0.
- R8: `done` rises exactly 2·(k+n) clock edges after the edge that accepted `start`.
- R9: `done` is high for exactly one cycle, and `valid` rises with it. `valid` and `crc_out` stay unchanged until the next accepted start.
- R10: A `start` pulse while `busy` is 1 is ignored. The running computation and its result are unaffected, and no extra `done` follows.
- R11: When k = 0, no message bits are absorbed and the engine goes straight to extraction of the loaded state.
- R12: The field `cfg_len_m1` encodes n - 1, so the values 0 to 31 select n = 1 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| cfg_mask | input | 32 | Polynomial tap mask; bit 0 is the highest-order coefficient |
| cfg_init | input | 32 | Starting state |
| cfg_len_m1 | input | 5 | CRC length minus one |
| msg_word | input | 32 | Message bits, right-aligned |
| msg_len | input | 6 | Number of message bits k (0 to 32) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | `crc_out` holds a finished result |
| crc_out | output | 32 | CRC result, right-aligned |

## Verification
The assertions watch rules that hold on every cycle. The state never carries bits at or above n. Each extract shift leaves a 0 in bit 0. `done` is a single-cycle pulse that comes with `valid` and never arrives while `busy` is still set. A start seen while idle always raises `busy`. The bench scenarios cover what only an end-to-end run can show. The finished CRC must equal a bit-level reference for several lengths, masks and message sizes, including k = 0, k = 1, n = 1 and n = 32. Completion must come at exactly 2·(k+n) edges. A start issued mid-run must leave the result untouched.

// File: rtl/crc_lfsr_pkg.sv
package crc_lfsr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ABS_PAR,
    PH_ABS_SHF,
    PH_EXT_PAR,
    PH_EXT_SHF
  } phase_e;
endpackage

// File: rtl/lfsr_parity.sv
// Registered masked parity: one of the two cycles spent per bit.
module lfsr_parity #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] state,
  input  logic [W-1:0] mask,
  output logic         par
);
  always_ff @(posedge clk) begin
    if (rst)     par <= 1'b0;
    else if (en) par <= ^(state & mask);
  end
endmodule

// File: rtl/lfsr_ctrl.sv
// Phase sequencer: absorb k bits, then extract n bits, two cycles per bit.
module lfsr_ctrl
  import crc_lfsr_pkg::*;
#(
  parameter int W  = 32,
  parameter int KW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [$clog2(W)-1:0]   cfg_len_m1,
  input  logic [$clog2(KW+1)-1:0] msg_len,
  output logic                   load,
  output logic                   par_en,
  output logic                   abs_shift,
  output logic                   ext_shift,
  output logic                   busy,
  output logic                   done,
  output logic                   valid
);
  localparam int LW   = $clog2(W);
  localparam int MAXC = (KW > W) ? KW : W;
  localparam int CW   = $clog2(MAXC + 1);

  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic [LW-1:0]   nm1_q;

  assign busy      = (phase_q != PH_IDLE);
  assign load      = (phase_q == PH_IDLE) && start;
  assign par_en    = (phase_q == PH_ABS_PAR) || (phase_q == PH_EXT_PAR);
  assign abs_shift = (phase_q == PH_ABS_SHF);
  assign ext_shift = (phase_q == PH_EXT_SHF);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      nm1_q   <= '0;
      done    <= 1'b0;
      valid   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            valid <= 1'b0;
            nm1_q <= cfg_len_m1;
            if (msg_len != '0) begin
              phase_q <= PH_ABS_PAR;
              cnt_q   <= CW'(msg_len);
            end else begin
              phase_q <= PH_EXT_PAR;
              cnt_q   <= CW'(cfg_len_m1) + CW'(1);
            end
          end
        end
        PH_ABS_PAR: phase_q <= PH_ABS_SHF;
        PH_ABS_SHF: begin
          if (cnt_q == CW'(1)) begin
            phase_q <= PH_EXT_PAR;
            cnt_q   <= CW'(nm1_q) + CW'(1);
          end else begin
            phase_q <= PH_ABS_PAR;
            cnt_q   <= cnt_q - CW'(1);
          end
        end
        PH_EXT_PAR: phase_q <= PH_EXT_SHF;
        PH_EXT_SHF: begin
          if (cnt_q == CW'(1)) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
            valid   <= 1'b1;
          end else begin
            phase_q <= PH_EXT_PAR;
            cnt_q   <= cnt_q - CW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_with_valid: assert property (@(posedge clk) disable iff (rst)
    done |-> (valid && !busy));
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r2_busy_not_valid: assert property (@(posedge clk) disable iff (rst)
    busy |-> !valid);
endmodule

// File: rtl/lfsr_datapath.sv
// State, mask, message and result registers of the external shift register.
module lfsr_datapath #(
  parameter int W  = 32,
  parameter int KW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    abs_shift,
  input  logic                    ext_shift,
  input  logic                    par,
  input  logic [W-1:0]            cfg_mask,
  input  logic [W-1:0]            cfg_init,
  input  logic [$clog2(W)-1:0]    cfg_len_m1,
  input  logic [KW-1:0]           msg_word,
  input  logic [$clog2(KW+1)-1:0] msg_len,
  output logic [W-1:0]            state_q,
  output logic [W-1:0]            mask_q,
  output logic [W-1:0]            result_q
);
  logic [W-1:0]  lenmask_q;
  logic [KW-1:0] word_q;
  logic [W-1:0]  lenmask_d;

  // n ones, right-aligned, for n = cfg_len_m1 + 1
  assign lenmask_d = {W{1'b1}} >> (W - 1 - int'(cfg_len_m1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= '0;
      mask_q    <= '0;
      result_q  <= '0;
      lenmask_q <= '0;
      word_q    <= '0;
    end else if (load) begin
      state_q   <= cfg_init & lenmask_d;
      mask_q    <= cfg_mask;
      lenmask_q <= lenmask_d;
      result_q  <= '0;
      // left-align so the first message bit sits in the top position
      word_q    <= (msg_len == '0) ? '0 : (msg_word << (KW - int'(msg_len)));
    end else if (abs_shift) begin
      state_q <= {state_q[W-2:0], par ^ word_q[KW-1]} & lenmask_q;
      word_q  <= {word_q[KW-2:0], 1'b0};
    end else if (ext_shift) begin
      state_q  <= {state_q[W-2:0], 1'b0} & lenmask_q;
      result_q <= {result_q[W-2:0], par};
    end
  end

  a_r7_state_width: assert property (@(posedge clk) disable iff (rst)
    (state_q & ~lenmask_q) == '0);
  a_r5_no_feedback: assert property (@(posedge clk) disable iff (rst)
    ext_shift |=> (state_q[0] == 1'b0));
  a_r6_result_width: assert property (@(posedge clk) disable iff (rst)
    (result_q & ~lenmask_q) == '0);
endmodule

// File: rtl/lfsr_crc_engine.sv
module lfsr_crc_engine #(
  parameter int W  = 32,
  parameter int KW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [W-1:0]            cfg_mask,
  input  logic [W-1:0]            cfg_init,
  input  logic [$clog2(W)-1:0]    cfg_len_m1,
  input  logic [KW-1:0]           msg_word,
  input  logic [$clog2(KW+1)-1:0] msg_len,
  output logic                    busy,
  output logic                    done,
  output logic                    valid,
  output logic [W-1:0]            crc_out
);
  logic load, par_en, abs_shift, ext_shift, par;
  logic [W-1:0] state_q, mask_q;

  lfsr_ctrl #(.W(W), .KW(KW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cfg_len_m1(cfg_len_m1),
    .msg_len(msg_len), .load(load), .par_en(par_en),
    .abs_shift(abs_shift), .ext_shift(ext_shift),
    .busy(busy), .done(done), .valid(valid)
  );

  lfsr_parity #(.W(W)) u_par (
    .clk(clk), .rst(rst), .en(par_en), .state(state_q), .mask(mask_q),
    .par(par)
  );

  lfsr_datapath #(.W(W), .KW(KW)) u_dp (
    .clk(clk), .rst(rst), .load(load), .abs_shift(abs_shift),
    .ext_shift(ext_shift), .par(par), .cfg_mask(cfg_mask),
    .cfg_init(cfg_init), .cfg_len_m1(cfg_len_m1), .msg_word(msg_word),
    .msg_len(msg_len), .state_q(state_q), .mask_q(mask_q),
    .result_q(crc_out)
  );

  a_r10_mask_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mask_q));
endmodule

// File: tb/sim_lfsr_crc_engine.sv
module sim_lfsr_crc_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] cfg_mask, cfg_init, msg_word;
  logic [4:0]  cfg_len_m1;
  logic [5:0]  msg_len;
  logic        busy, done, valid;
  logic [31:0] crc_out;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit summary_done = 0;

  logic [31:0] exp_crc_q[$];
  int          exp_lat_q[$];

  always #4 clk = ~clk;

  lfsr_crc_engine u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_mask(cfg_mask),
    .cfg_init(cfg_init), .cfg_len_m1(cfg_len_m1), .msg_word(msg_word),
    .msg_len(msg_len), .busy(busy), .done(done), .valid(valid),
    .crc_out(crc_out)
  );

  // edges since the last accepted start
  always @(posedge clk) begin
    if (start && !busy && !rst) edges <= 0;
    else                        edges <= edges + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] m, input logic [31:0] init,
                                         input int n, input logic [31:0] w, input int k);
    logic [31:0] lm, s, r;
    lm = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    s = init & lm;
    for (int i = k - 1; i >= 0; i--) s = ((s << 1) | {31'b0, (^(s & m)) ^ w[i]}) & lm;
    r = '0;
    for (int j = 0; j < n; j++) begin
      r = (r << 1) | {31'b0, ^(s & m)};
      s = (s << 1) & lm;
    end
    return r;
  endfunction

  // monitor: pop expected result on each done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_crc_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", {31'b0, done}, 32'h0);
      end else begin
        logic [31:0] ec;
        int el;
        ec = exp_crc_q.pop_front();
        el = exp_lat_q.pop_front();
        chk(crc_out === ec, "R3/R5/R6 crc value", crc_out, ec);
        chk(edges == el, "R8 latency", edges, el);
        chk(valid === 1'b1, "R9 valid with done", {31'b0, valid}, 32'h1);
      end
    end
  end

  task automatic run_case(input logic [31:0] m, input logic [31:0] init, input int n,
                          input logic [31:0] w, input int k);
    logic [31:0] wk;
    while (busy) @(negedge clk);
    wk = (k == 32) ? w : (w & ((32'h1 << k) - 32'h1));
    exp_crc_q.push_back(model(m, init, n, wk, k));
    exp_lat_q.push_back(2 * (k + n));
    cfg_mask = m; cfg_init = init; cfg_len_m1 = 5'(n - 1);
    msg_word = w; msg_len = 6'(k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", {31'b0, busy}, 32'h1);
    chk(valid === 1'b0, "R2 valid cleared", {31'b0, valid}, 32'h0);
  endtask

  task automatic wait_done();
    while (exp_crc_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", {31'b0, done}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0;
    cfg_mask = '0; cfg_init = '0; cfg_len_m1 = '0; msg_word = '0; msg_len = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk({busy, done, valid} === 3'b000, "R1 flags after reset", {29'b0, busy, done, valid}, 32'h0);
    chk(crc_out === 32'h0, "R1 result after reset", crc_out, 32'h0);

    // n=8, full message; upper word bits beyond k ignored (R4)
    run_case(32'h0000_00E0, 32'h0000_0000, 8, 32'hDEAD_BEEF, 32); wait_done();
    run_case(32'h0000_00E0, 32'h0000_00FF, 8, 32'hFFFF_FF3C, 8);  wait_done();
    // n=32, R7 via init wider than n covered in next case
    run_case(32'hEDB8_8320, 32'hFFFF_FFFF, 32, 32'h1234_5678, 32); wait_done();
    run_case(32'h0000_8408, 32'hABCD_FFFF, 16, 32'hCAFE_0055, 12); wait_done();
    // R11: k = 0
    run_case(32'h0000_0009, 32'h0000_000B, 4, 32'hFFFF_FFFF, 0);  wait_done();
    // R12 / boundary n = 1, k = 1
    run_case(32'h0000_0001, 32'h0000_0001, 1, 32'h0000_0001, 1);  wait_done();
    run_case(32'h0000_0005, 32'h0000_0003, 3, 32'h0000_0002, 2);  wait_done();

    // R10: start while busy is ignored
    run_case(32'h0000_1021, 32'h0000_FFFF, 16, 32'h0F0F_A5A5, 20);
    repeat (3) @(negedge clk);
    cfg_mask = 32'hFFFF_FFFF; cfg_init = 32'h0; cfg_len_m1 = 5'd2;
    msg_word = 32'h0; msg_len = 6'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    begin
      logic [31:0] held;
      held = crc_out;
      repeat (6) @(negedge clk);
      chk(crc_out === held, "R9 result held", crc_out, held);
      chk(valid === 1'b1, "R9 valid held", {31'b0, valid}, 32'h1);
      chk(busy === 1'b0, "R10 no restart", {31'b0, busy}, 32'h0);
    end

    if (!summary_done) begin
      summary_done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      summary_done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end
endmodule